// File: doc/BRIEF.md
# Dual-Port Interrupt-on-Change Controller

The block watches two 8-bit input ports and keeps one interrupt flag for each. The flag rises when an enabled input pin changes. Each pin chooses how a change is detected: either against the value the pin had on the previous cycle, or against a bit in a programmable default word. The first qualifying event on a port latches the whole synchronized port into that port's capture register. Later events on the same port are ignored until software reads the port's data or capture register.

Register contents arrive as plain inputs. Completion of a register read arrives as a one-cycle read-done strobe for each port and register. The two flags can be routed one per output, or ORed onto both outputs. Each output can be active-high, active-low or open-drain. In open-drain mode the block drives a value together with an output enable.

Top module: `ioc_irq_ctrl`

## Requirements
- R1: A pin whose bit in the enable input is 0 never sets its port's flag.
- R2: A pin whose bit in the direction input is 0 (output) never sets its port's flag. A bit value of 1 marks the pin as an input.
- R3: With its compare-select bit at 0, an enabled input pin sets the flag when its synchronized value differs from its value one cycle earlier. The flag is visible on the third rising edge after the pin changes.
- R4: With its compare-select bit at 1, an enabled input pin sets the flag whenever its synchronized value differs from the matching bit of the default word. This holds even if the pin never toggles.
- R5: The event that sets a flag copies the synchronized port into that port's capture output. While the flag is set, further events change neither the flag nor the capture value.
- R6: A read-done strobe for a port's data register or capture register clears that port's flag on the next rising edge. Strobes for the other port have no effect on it.
- R7: If a mismatch is still present after a clear, the flag sets again one cycle later and the capture output reloads with the current port value.
- R8: With mirror at 0, output A follows flag A and output B follows flag B. With mirror at 1, both outputs follow the OR of the two flags.
- R9: Drive mode per output: 00 gives active-high (oe=1), 01 gives active-low (oe=1), and 1x gives open-drain. In open-drain mode the value is 0 and oe equals the active state.
- R10: Reset clears both flags and both capture registers. No event is raised while the synchronizer and previous-value registers settle after reset, even if pins are held at a non-zero value.
- R11: The two ports are independent. An event on port B does not set flag A, and the reverse also holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_a_i | input | 8 | Port A pins (asynchronous) |
| pin_b_i | input | 8 | Port B pins (asynchronous) |
| dir_in_a_i | input | 8 | Port A direction, 1 = input |
| dir_in_b_i | input | 8 | Port B direction, 1 = input |
| ien_a_i | input | 8 | Port A per-pin interrupt enable |
| ien_b_i | input | 8 | Port B per-pin interrupt enable |
| cmp_def_a_i | input | 8 | Port A compare select, 1 = default word |
| cmp_def_b_i | input | 8 | Port B compare select, 1 = default word |
| def_a_i | input | 8 | Port A default word |
| def_b_i | input | 8 | Port B default word |
| mirror_i | input | 1 | OR both flags onto both outputs |
| mode_a_i | input | 2 | Output A drive mode |
| mode_b_i | input | 2 | Output B drive mode |
| rd_data_a_i | input | 1 | Port A data register read done |
| rd_cap_a_i | input | 1 | Port A capture register read done |
| rd_data_b_i | input | 1 | Port B data register read done |
| rd_cap_b_i | input | 1 | Port B capture register read done |
| data_a_o | output | 8 | Synchronized port A value |
| data_b_o | output | 8 | Synchronized port B value |
| cap_a_o | output | 8 | Port A capture register |
| cap_b_o | output | 8 | Port B capture register |
| int_a_o | output | 1 | Interrupt output A value |
| int_a_oe_o | output | 1 | Interrupt output A drive enable |
| int_b_o | output | 1 | Interrupt output B value |
| int_b_oe_o | output | 1 | Interrupt output B drive enable |

## Verification
The bench holds port pins at a non-zero value through reset. A design that armed its comparator before the synchronizer settled would raise a false event there. It moves the pins a second time while a flag is pending, which catches a capture register that keeps reloading instead of keeping the first value. It clears a flag while a default-word mismatch persists and expects the flag to return one cycle later with the newer port value. A design that lost the pending mismatch, or kept the stale capture, fails at that point. It also sets mirror mode and strobes a read of the other port: a design that cleared both flags on any read would drop output A.

// File: rtl/ioc_pkg.sv
package ioc_pkg;
  typedef enum logic [1:0] {
    DRV_HIGH = 2'b00,
    DRV_LOW  = 2'b01,
    DRV_OD   = 2'b10,
    DRV_OD2  = 2'b11
  } drv_mode_e;
endpackage

// File: rtl/ioc_sync.sv
module ioc_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ioc_port.sv
module ioc_port #(
  parameter int W      = 8,
  parameter int SETTLE = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] dir_in_i,
  input  logic [W-1:0] ien_i,
  input  logic [W-1:0] cmp_def_i,
  input  logic [W-1:0] def_i,
  input  logic         clr_i,
  output logic         flag_o,
  output logic [W-1:0] cap_o
);
  localparam int CW = $clog2(SETTLE + 1);

  logic [CW-1:0] arm_q;
  logic          armed;
  logic [W-1:0]  prev_q;
  logic [W-1:0]  mism;
  logic          hit;

  assign armed = (arm_q == CW'(SETTLE));

  // hold off events until synchronizer and prev register carry real pin data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) arm_q <= '0;
    else if (!armed) arm_q <= arm_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else prev_q <= pin_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_cmp
    assign mism[i] = cmp_def_i[i] ? (pin_i[i] ^ def_i[i]) : (pin_i[i] ^ prev_q[i]);
  end

  assign hit = armed & |(mism & ien_i & dir_in_i);

  // clear wins; a persisting mismatch re-sets on the following edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
      cap_o  <= '0;
    end else if (clr_i) begin
      flag_o <= 1'b0;
    end else if (!flag_o && hit) begin
      flag_o <= 1'b1;
      cap_o  <= pin_i;
    end
  end
endmodule

// File: rtl/ioc_drv.sv
module ioc_drv
  import ioc_pkg::*;
(
  input  logic       act_i,
  input  logic [1:0] mode_i,
  output logic       pad_o,
  output logic       oe_o
);
  always_comb begin
    case (drv_mode_e'(mode_i))
      DRV_HIGH: begin pad_o = act_i;  oe_o = 1'b1;  end
      DRV_LOW:  begin pad_o = ~act_i; oe_o = 1'b1;  end
      default:  begin pad_o = 1'b0;   oe_o = act_i; end
    endcase
  end
endmodule

// File: rtl/ioc_irq_ctrl.sv
module ioc_irq_ctrl #(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_a_i,
  input  logic [W-1:0] pin_b_i,
  input  logic [W-1:0] dir_in_a_i,
  input  logic [W-1:0] dir_in_b_i,
  input  logic [W-1:0] ien_a_i,
  input  logic [W-1:0] ien_b_i,
  input  logic [W-1:0] cmp_def_a_i,
  input  logic [W-1:0] cmp_def_b_i,
  input  logic [W-1:0] def_a_i,
  input  logic [W-1:0] def_b_i,
  input  logic         mirror_i,
  input  logic [1:0]   mode_a_i,
  input  logic [1:0]   mode_b_i,
  input  logic         rd_data_a_i,
  input  logic         rd_cap_a_i,
  input  logic         rd_data_b_i,
  input  logic         rd_cap_b_i,
  output logic [W-1:0] data_a_o,
  output logic [W-1:0] data_b_o,
  output logic [W-1:0] cap_a_o,
  output logic [W-1:0] cap_b_o,
  output logic         int_a_o,
  output logic         int_a_oe_o,
  output logic         int_b_o,
  output logic         int_b_oe_o
);
  localparam int NP     = 2;
  localparam int SETTLE = SYNC_STAGES + 1;

  logic [W-1:0] pin_raw [NP];
  logic [W-1:0] pin_s   [NP];
  logic [W-1:0] dir_v   [NP];
  logic [W-1:0] ien_v   [NP];
  logic [W-1:0] sel_v   [NP];
  logic [W-1:0] def_v   [NP];
  logic [W-1:0] cap_v   [NP];
  logic [1:0]   mode_v  [NP];
  logic [NP-1:0] clr, flag, act, pad, oe;

  assign pin_raw[0] = pin_a_i;     assign pin_raw[1] = pin_b_i;
  assign dir_v[0]   = dir_in_a_i;  assign dir_v[1]   = dir_in_b_i;
  assign ien_v[0]   = ien_a_i;     assign ien_v[1]   = ien_b_i;
  assign sel_v[0]   = cmp_def_a_i; assign sel_v[1]   = cmp_def_b_i;
  assign def_v[0]   = def_a_i;     assign def_v[1]   = def_b_i;
  assign mode_v[0]  = mode_a_i;    assign mode_v[1]  = mode_b_i;
  assign clr        = {rd_data_b_i | rd_cap_b_i, rd_data_a_i | rd_cap_a_i};

  for (genvar p = 0; p < NP; p++) begin : g_port
    ioc_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i, .rst_ni, .d_i(pin_raw[p]), .q_o(pin_s[p])
    );
    ioc_port #(.W(W), .SETTLE(SETTLE)) u_port (
      .clk_i, .rst_ni,
      .pin_i(pin_s[p]), .dir_in_i(dir_v[p]), .ien_i(ien_v[p]),
      .cmp_def_i(sel_v[p]), .def_i(def_v[p]), .clr_i(clr[p]),
      .flag_o(flag[p]), .cap_o(cap_v[p])
    );
    assign act[p] = mirror_i ? |flag : flag[p];
    ioc_drv u_drv (.act_i(act[p]), .mode_i(mode_v[p]), .pad_o(pad[p]), .oe_o(oe[p]));
  end

  assign data_a_o   = pin_s[0];
  assign data_b_o   = pin_s[1];
  assign cap_a_o    = cap_v[0];
  assign cap_b_o    = cap_v[1];
  assign int_a_o    = pad[0];
  assign int_a_oe_o = oe[0];
  assign int_b_o    = pad[1];
  assign int_b_oe_o = oe[1];
endmodule

// File: rtl/ioc_irq_ctrl_chk.sv
module ioc_irq_ctrl_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [1:0]   flag,
  input logic         rd_data_a_i,
  input logic         rd_cap_a_i,
  input logic         rd_data_b_i,
  input logic         rd_cap_b_i,
  input logic [W-1:0] cap_a_o,
  input logic [W-1:0] cap_b_o,
  input logic         mirror_i,
  input logic [1:0]   mode_a_i,
  input logic [1:0]   mode_b_i,
  input logic         int_a_o,
  input logic         int_a_oe_o,
  input logic         int_b_o,
  input logic         int_b_oe_o
);
  a_r6_clear_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_a_i || rd_cap_a_i) |=> !flag[0]);
  a_r6_clear_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_b_i || rd_cap_b_i) |=> !flag[1]);
  a_r5_hold_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag[0] && !rd_data_a_i && !rd_cap_a_i) |=> (flag[0] && $stable(cap_a_o)));
  a_r5_hold_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag[1] && !rd_data_b_i && !rd_cap_b_i) |=> (flag[1] && $stable(cap_b_o)));
  a_r5_cap_on_set_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cap_a_o) |-> $rose(flag[0]));
  a_r5_cap_on_set_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cap_b_o) |-> $rose(flag[1]));
  a_r8_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mirror_i && mode_a_i == mode_b_i) |-> (int_a_o == int_b_o && int_a_oe_o == int_b_oe_o));
  a_r9_od_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_a_i[1] |-> (!int_a_o && int_a_oe_o == (mirror_i ? |flag : flag[0])));
  a_r9_od_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_b_i[1] |-> (!int_b_o && int_b_oe_o == (mirror_i ? |flag : flag[1])));
endmodule

bind ioc_irq_ctrl ioc_irq_ctrl_chk #(.W(W)) u_chk (
  .clk_i, .rst_ni, .flag,
  .rd_data_a_i, .rd_cap_a_i, .rd_data_b_i, .rd_cap_b_i,
  .cap_a_o, .cap_b_o, .mirror_i, .mode_a_i, .mode_b_i,
  .int_a_o, .int_a_oe_o, .int_b_o, .int_b_oe_o
);

// File: tb/ioc_irq_ctrl_test.sv
`timescale 1ns/1ps
module ioc_irq_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] pin_a = '0, pin_b = '0, dir_a = 8'hFF, dir_b = 8'hFF;
  logic [7:0] ien_a = '0, ien_b = '0, sel_a = '0, sel_b = '0, def_a = '0, def_b = '0;
  logic mirror = 1'b0;
  logic [1:0] mode_a = 2'b00, mode_b = 2'b00;
  logic rda = 1'b0, rca = 1'b0, rdb = 1'b0, rcb = 1'b0;
  logic [7:0] data_a, data_b, cap_a, cap_b;
  logic int_a, int_a_oe, int_b, int_b_oe;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ioc_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .pin_a_i(pin_a), .pin_b_i(pin_b),
    .dir_in_a_i(dir_a), .dir_in_b_i(dir_b), .ien_a_i(ien_a), .ien_b_i(ien_b),
    .cmp_def_a_i(sel_a), .cmp_def_b_i(sel_b), .def_a_i(def_a), .def_b_i(def_b),
    .mirror_i(mirror), .mode_a_i(mode_a), .mode_b_i(mode_b),
    .rd_data_a_i(rda), .rd_cap_a_i(rca), .rd_data_b_i(rdb), .rd_cap_b_i(rcb),
    .data_a_o(data_a), .data_b_o(data_b), .cap_a_o(cap_a), .cap_b_o(cap_b),
    .int_a_o(int_a), .int_a_oe_o(int_a_oe), .int_b_o(int_b), .int_b_oe_o(int_b_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  typedef struct packed {
    logic [7:0] ien, sel, dflt, dir, pin;
    logic       exp_int;
    logic [7:0] exp_cap;
  } vec_t;

  localparam vec_t VT [7] = '{
    '{8'hFF, 8'h00, 8'h00, 8'hFF, 8'h01, 1'b1, 8'h01},  // R3 change
    '{8'hFE, 8'h00, 8'h00, 8'hFF, 8'h01, 1'b0, 8'h00},  // R1 disabled pin
    '{8'hFF, 8'h00, 8'h00, 8'hF0, 8'h0F, 1'b0, 8'h00},  // R2 outputs ignored
    '{8'hFF, 8'hFF, 8'h00, 8'hFF, 8'h00, 1'b0, 8'h00},  // R4 default match
    '{8'hFF, 8'h01, 8'h00, 8'hFF, 8'h01, 1'b1, 8'h01},  // R4 default mismatch
    '{8'h80, 8'h00, 8'h00, 8'hFF, 8'h80, 1'b1, 8'h80},  // R3 top bit
    '{8'h01, 8'h01, 8'h01, 8'hFF, 8'h00, 1'b1, 8'h00}   // R4 no toggle
  };

  initial begin : watchdog
    #(200000 * 8);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    pin_b = 8'hFF; ien_b = 8'hFF;  // R10 pins high through reset
    wait_n(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset int_a", int_a, 0);
    chk("R10 reset int_b", int_b, 0);
    chk("R10 reset cap_a", cap_a, 0);
    chk("R10 reset cap_b", cap_b, 0);
    chk("R9 mode00 oe", int_a_oe, 1);
    wait_n(6);
    chk("R10 no event after reset", int_b, 0);
    ien_b = 8'h00; pin_b = 8'h00;
    wait_n(4);

    foreach (VT[k]) begin
      ien_a = VT[k].ien; sel_a = VT[k].sel; def_a = VT[k].dflt;
      dir_a = VT[k].dir; pin_a = VT[k].pin;
      wait_n(3);
      chk($sformatf("R1/R2/R3/R4 vec%0d int", k), int_a, VT[k].exp_int);
      if (VT[k].exp_int) chk($sformatf("R5 vec%0d cap", k), cap_a, VT[k].exp_cap);
      ien_a = '0; pin_a = '0;
      wait_n(4);
      rca = 1'b1; @(negedge clk); rca = 1'b0;
      chk($sformatf("R6 vec%0d cleared", k), int_a, 0);
    end
    sel_a = '0; def_a = '0; dir_a = 8'hFF;
    wait_n(2);

    // R5 / R7: default mode, pending mismatch re-arms after data read
    ien_a = 8'hFF; sel_a = 8'hFF; def_a = 8'h00; pin_a = 8'h01;
    wait_n(3);
    chk("R5 first cap", cap_a, 8'h01);
    pin_a = 8'h03;
    wait_n(4);
    chk("R5 held int", int_a, 1);
    chk("R5 held cap", cap_a, 8'h01);
    rda = 1'b1; @(negedge clk); rda = 1'b0;
    chk("R6 data read clears", int_a, 0);
    @(negedge clk);
    chk("R7 re-armed", int_a, 1);
    chk("R7 cap reloaded", cap_a, 8'h03);

    // R8: mirror, other port's read leaves flag A
    ien_a = 8'h00; mirror = 1'b1;
    @(negedge clk);
    chk("R8 mirror int_b", int_b, 1);
    rdb = 1'b1; @(negedge clk); rdb = 1'b0;
    @(negedge clk);
    chk("R8 read B keeps A on out A", int_a, 1);
    chk("R8 read B keeps A on out B", int_b, 1);
    rca = 1'b1; @(negedge clk); rca = 1'b0;
    chk("R8 read A clears out A", int_a, 0);
    chk("R8 read A clears out B", int_b, 0);
    mirror = 1'b0;

    // R11: event on B only
    ien_b = 8'hFF; pin_b = 8'h20;
    wait_n(3);
    chk("R11 int_b set", int_b, 1);
    chk("R11 int_a clear", int_a, 0);
    chk("R11 cap_b", cap_b, 8'h20);
    chk("R8 unmirrored int_a", int_a, 0);
    ien_b = 8'h00; rcb = 1'b1; @(negedge clk); rcb = 1'b0;
    chk("R6 cap read clears B", int_b, 0);

    // R9: drive modes, flag A set again via default mismatch (pin 03 vs 00)
    ien_a = 8'hFF;
    wait_n(2);
    mode_a = 2'b01; #1;
    chk("R9 low active val", int_a, 0);
    chk("R9 low active oe", int_a_oe, 1);
    mode_a = 2'b10; #1;
    chk("R9 od active val", int_a, 0);
    chk("R9 od active oe", int_a_oe, 1);
    ien_a = 8'h00;
    @(negedge clk);
    rda = 1'b1; @(negedge clk); rda = 1'b0;
    chk("R9 od idle oe", int_a_oe, 0);
    mode_a = 2'b01; #1;
    chk("R9 low idle val", int_a, 1);
    mode_a = 2'b00;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule